// File: doc/BRIEF.md
# Decode-Stage Branch Resolver and Fetch Address Sequencer

This block holds the fetch address of a five-stage in-order pipeline and chooses the next one. It resolves conditional branches and unconditional jumps in the decode stage. A zero detector tests the single register operand of the branch in decode. A dedicated adder forms the target from the branch's own address and its sign-extended word offset. Because the decision is made in decode, a taken transfer reaches the fetch address at the next clock edge. At most one fetched instruction lies in its shadow.

The instruction in that shadow slot is handled by a policy captured at reset. In delay-slot mode, the slot instruction always runs and nothing is squashed. In predict-not-taken mode, fetch runs straight on. The slot instruction is squashed through a one-cycle flush strobe to the IF/ID register, but only when the transfer turns out taken. The cycle that follows a flush holds a bubble in decode, so any branch indication seen in that cycle is ignored. The surrounding pipeline drives the decode fields. It uses the flush strobe to load a no-op into IF/ID.

Top module: `pcseq_top`

## Requirements
- R1: While reset is asserted, `fetchPc` is held at the parameter `RESET_VEC`, and `flushIfId` and `taken` are 0.
- R2: With no branch or jump in decode, `fetchPc` advances by 4 at each clock edge.
- R3: A conditional branch (`decBranch`=1) is taken when `decCond`=0 and `decReg` is zero, or when `decCond`=1 and `decReg` is nonzero. Otherwise it is not taken and `fetchPc` advances by 4.
- R4: For a taken branch, the `fetchPc` after the next edge is `decPc` + 4 + (`decImm` shifted left by 2), with wrap-around in the address width. `nextPc` shows this value in the decision cycle.
- R5: A jump (`decJump`=1) is always taken, and the `fetchPc` after the next edge equals `jumpTarget`.
- R6: With predict-not-taken selected (`policyIn`=1 at reset), `flushIfId` is 1 in exactly the cycles where `taken` is 1. A not-taken branch causes no flush.
- R7: With delay-slot mode selected (`policyIn`=0 at reset), `flushIfId` stays 0 even for taken branches and jumps.
- R8: In the cycle after a flush, `decBranch` and `decJump` are ignored: `taken` and `flushIfId` are 0, and `fetchPc` advances by 4.
- R9: `policyIn` is captured only while reset is asserted. Changing it afterwards has no effect on flushing.
- R10: When `decBranch` and `decJump` are both 1, the jump wins, and the `fetchPc` after the next edge equals `jumpTarget`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| policyIn | input | 1 | Shadow-slot policy, 0 delay slot, 1 predict-not-taken; captured during reset |
| decBranch | input | 1 | Conditional branch in decode |
| decJump | input | 1 | Unconditional jump in decode |
| decCond | input | 1 | Branch kind, 0 branch if zero, 1 branch if nonzero |
| decPc | input | W | Address of the instruction in decode |
| decReg | input | W | Register operand tested by the branch |
| decImm | input | W | Sign-extended word offset of the branch |
| jumpTarget | input | W | Absolute jump destination |
| fetchPc | output | W | Current fetch address |
| nextPc | output | W | Fetch address to be loaded at the next edge |
| flushIfId | output | 1 | Load a no-op into the IF/ID register at the next edge |
| taken | output | 1 | Control transfer taken this cycle |

## Verification
The zero test is tried with a zero and a nonzero operand under both branch kinds. This separates an inverted or missing condition from a correct one. Positive and negative offsets show whether the offset is scaled and whether the adder starts from the branch's address plus 4. A branch held through the cycle after a flush, a jump combined with a branch, and a policy input toggled after reset each isolate one piece of control behaviour. Both policies are run, so a design that always flushes or never flushes is caught.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  typedef enum logic {
    POL_DELAY = 1'b0,
    POL_PNT   = 1'b1
  } slotPolicy_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadBranch;
    logic loadJump;
    logic squash;
  } seqStrobe_t;

endpackage

// File: rtl/pcseq_datapath.sv
module pcseq_datapath
  import pcseq_pkg::*;
#(
  parameter int W           = 32,
  parameter int INSTR_BYTES = 4,
  parameter logic [W-1:0] RESET_VEC = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  seqStrobe_t   strobe,
  input  logic [W-1:0] decPc,
  input  logic [W-1:0] decReg,
  input  logic [W-1:0] decImm,
  input  logic [W-1:0] jumpTarget,
  output logic         regIsZero,
  output logic [W-1:0] fetchPc,
  output logic [W-1:0] nextPc
);

  localparam int SHIFT = $clog2(INSTR_BYTES);
  localparam logic [W-1:0] STEP = W'(INSTR_BYTES);

  logic [W-1:0] fetchPcQ;
  logic [W-1:0] seqPc;
  logic [W-1:0] linkPc;
  logic [W-1:0] branchTgt;

  // zero detector in decode
  assign regIsZero = (decReg == '0);

  // sequential and target adders
  assign seqPc     = fetchPcQ + STEP;
  assign linkPc    = decPc + STEP;
  assign branchTgt = linkPc + (decImm << SHIFT);

  always_comb begin
    if (strobe.loadJump)        nextPc = jumpTarget;
    else if (strobe.loadBranch) nextPc = branchTgt;
    else                        nextPc = seqPc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) fetchPcQ <= RESET_VEC;
    else       fetchPcQ <= nextPc;
  end

  assign fetchPc = fetchPcQ;

  // R10: control never asks for both redirections at once
  assert_single_redirect_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadBranch, strobe.loadJump}));

  // R2: without a redirection the fetch address steps by one instruction
  assert_seq_advance_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadBranch || strobe.loadJump) |=> fetchPc == $past(fetchPc) + STEP);

endmodule

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
  import pcseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       policyIn,
  input  logic       decBranch,
  input  logic       decJump,
  input  logic       decCond,
  input  logic       regIsZero,
  output seqStrobe_t strobe,
  output logic       taken
);

  slotPolicy_e policyQ;
  logic        afterFlushQ;
  logic        live;
  logic        condMet;
  logic        jumpGo;
  logic        branchGo;

  // decode slot holds a bubble right after a squash
  assign live     = !afterFlushQ;
  assign condMet  = decCond ? !regIsZero : regIsZero;
  assign jumpGo   = live && decJump;
  assign branchGo = live && decBranch && !decJump && condMet;
  assign taken    = jumpGo || branchGo;

  always_comb begin
    strobe.loadJump   = jumpGo;
    strobe.loadBranch = branchGo;
    strobe.squash     = taken && (policyQ == POL_PNT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      policyQ     <= slotPolicy_e'(policyIn);
      afterFlushQ <= 1'b0;
    end else begin
      afterFlushQ <= strobe.squash;
    end
  end

  // R6: a squash only accompanies a taken transfer
  assert_flush_needs_taken_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.squash |-> taken);

  // R7: delay-slot mode never squashes
  assert_delay_no_flush_R7: assert property (@(posedge clk) disable iff (!rstN)
    (policyQ == POL_DELAY) |-> !strobe.squash);

  // R8: the bubble after a squash cannot redirect
  assert_bubble_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.squash |=> (!taken && !strobe.squash));

  // R9: captured policy holds after reset
  assert_policy_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $stable(policyQ));

  // R3: no indication in decode means no transfer
  assert_idle_not_taken_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(decBranch || decJump) |-> !taken);

endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
  import pcseq_pkg::*;
#(
  parameter int W           = 32,
  parameter int INSTR_BYTES = 4,
  parameter logic [W-1:0] RESET_VEC = 32'h0000_1000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         policyIn,
  input  logic         decBranch,
  input  logic         decJump,
  input  logic         decCond,
  input  logic [W-1:0] decPc,
  input  logic [W-1:0] decReg,
  input  logic [W-1:0] decImm,
  input  logic [W-1:0] jumpTarget,
  output logic [W-1:0] fetchPc,
  output logic [W-1:0] nextPc,
  output logic         flushIfId,
  output logic         taken
);

  seqStrobe_t strobe;
  logic       regIsZero;

  pcseq_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .policyIn  (policyIn),
    .decBranch (decBranch),
    .decJump   (decJump),
    .decCond   (decCond),
    .regIsZero (regIsZero),
    .strobe    (strobe),
    .taken     (taken)
  );

  pcseq_datapath #(
    .W           (W),
    .INSTR_BYTES (INSTR_BYTES),
    .RESET_VEC   (RESET_VEC)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .decPc      (decPc),
    .decReg     (decReg),
    .decImm     (decImm),
    .jumpTarget (jumpTarget),
    .regIsZero  (regIsZero),
    .fetchPc    (fetchPc),
    .nextPc     (nextPc)
  );

  assign flushIfId = strobe.squash;

endmodule

// File: tb/pcseq_top_tb_top.sv
`timescale 1ns/1ps
module pcseq_top_tb_top;

  localparam int W = 32;
  localparam logic [W-1:0] RST_VEC = 32'h0000_1000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         policyIn = 1'b1;
  logic         decBranch = 1'b0, decJump = 1'b0, decCond = 1'b0;
  logic [W-1:0] decPc = '0, decReg = '0, decImm = '0, jumpTarget = '0;
  logic [W-1:0] fetchPc, nextPc;
  logic         flushIfId, taken;

  always #2.5 clk = ~clk;

  pcseq_top #(.W(W), .RESET_VEC(RST_VEC)) dut_i (
    .clk(clk), .rstN(rstN), .policyIn(policyIn),
    .decBranch(decBranch), .decJump(decJump), .decCond(decCond),
    .decPc(decPc), .decReg(decReg), .decImm(decImm), .jumpTarget(jumpTarget),
    .fetchPc(fetchPc), .nextPc(nextPc), .flushIfId(flushIfId), .taken(taken)
  );

  typedef struct {
    string        tag;
    logic         flush;
    logic         tk;
    logic [W-1:0] pc;
  } expItem_t;

  expItem_t     sbQ[$];
  int           nChecks = 0;
  int           nFails = 0;
  bit           pntModel;
  bit           afterFlushModel;
  logic [W-1:0] expFetch;

  function automatic void check(string tag, logic [W-1:0] act, logic [W-1:0] exp, string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endfunction

  // driver: called at a falling edge, drives one decode cycle and queues the expectation
  task automatic step(string tag, logic br, logic jmp, logic cnd,
                      logic [W-1:0] rv, logic [W-1:0] imm, logic [W-1:0] jt);
    expItem_t it;
    logic     met;
    logic [W-1:0] bpc;
    bpc = expFetch - 32'd4;
    decBranch = br; decJump = jmp; decCond = cnd;
    decPc = bpc; decReg = rv; decImm = imm; jumpTarget = jt;
    met = cnd ? (rv != '0) : (rv == '0);
    it.tag = tag;
    it.tk  = !afterFlushModel && (jmp || (br && met));
    it.flush = it.tk && pntModel;
    if (!it.tk)   it.pc = expFetch + 32'd4;
    else if (jmp) it.pc = jt;
    else          it.pc = bpc + 32'd4 + (imm * 32'd4);
    sbQ.push_back(it);
    expFetch = it.pc;
    afterFlushModel = it.flush;
    @(negedge clk);
  endtask

  // monitor: compares strobes mid-cycle and the fetch address after the edge
  initial begin
    forever begin
      expItem_t it;
      @(negedge clk);
      #1;
      if (sbQ.size() != 0) begin
        it = sbQ.pop_front();
        check(it.tag, {31'd0, taken}, {31'd0, it.tk}, "taken");
        check(it.tag, {31'd0, flushIfId}, {31'd0, it.flush}, "flushIfId");
        @(posedge clk);
        #1;
        check(it.tag, fetchPc, it.pc, "fetchPc");
      end
    end
  end

  task automatic doReset(logic pol);
    @(negedge clk);
    rstN = 1'b0; policyIn = pol;
    decBranch = 1'b0; decJump = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", fetchPc, RST_VEC, "fetchPc in reset");
    check("R1", {31'd0, flushIfId}, 32'd0, "flushIfId in reset");
    check("R1", {31'd0, taken}, 32'd0, "taken in reset");
    rstN = 1'b1;
    pntModel = pol;
    afterFlushModel = 1'b0;
    expFetch = RST_VEC;
  endtask

  initial begin : watchdog
    #(200000 * 5);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    // predict-not-taken phase
    doReset(1'b1);
    step("R2", 0, 0, 0, 32'd0, 32'd0, 32'd0);
    step("R2", 0, 0, 0, 32'd0, 32'd0, 32'd0);
    step("R4", 1, 0, 0, 32'd0, 32'd5, 32'd0);          // R3 zero taken, R6 flush
    step("R8", 1, 0, 0, 32'd0, 32'd9, 32'd0);          // ignored in bubble
    step("R3", 1, 0, 0, 32'd7, 32'd5, 32'd0);          // zero test fails, R6 no flush
    step("R3", 1, 0, 1, 32'd7, 32'hFFFF_FFFD, 32'd0);  // nonzero taken, R4 negative
    step("R2", 0, 0, 0, 32'd0, 32'd0, 32'd0);
    step("R3", 1, 0, 1, 32'd0, 32'd8, 32'd0);          // nonzero test fails
    step("R5", 0, 1, 0, 32'd0, 32'd0, 32'h0000_4000);  // R6 flush on jump
    step("R2", 0, 0, 0, 32'd0, 32'd0, 32'd0);
    step("R10", 1, 1, 0, 32'd0, 32'd3, 32'h0000_8000);
    step("R2", 0, 0, 0, 32'd0, 32'd0, 32'd0);
    policyIn = 1'b0;
    step("R9", 1, 0, 0, 32'd0, 32'd2, 32'd0);          // still flushes
    step("R2", 0, 0, 0, 32'd0, 32'd0, 32'd0);
    // delay-slot phase
    doReset(1'b0);
    step("R2", 0, 0, 0, 32'd0, 32'd0, 32'd0);
    step("R7", 1, 0, 0, 32'd0, 32'd6, 32'd0);
    step("R7", 0, 0, 0, 32'd0, 32'd0, 32'd0);          // slot runs on
    step("R7", 0, 1, 0, 32'd0, 32'd0, 32'h0000_2000);
    step("R2", 0, 0, 0, 32'd0, 32'd0, 32'd0);
    policyIn = 1'b1;
    step("R9", 1, 0, 1, 32'd1, 32'd4, 32'd0);          // still no flush
    step("R2", 0, 0, 0, 32'd0, 32'd0, 32'd0);
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule